// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block serves one DMA channel whose external request line is active low and level sensitive. Software arms the channel by writing its enable bit. From the clock edge after the one that stores the enable, the block samples the request line on every edge. A low level seen while the block is idle and enabled is stored as a pending request. The block then asks the bus arbiter for a bus break.

When the arbiter grants the break, the pending request is cleared and one single-address transfer starts. The acknowledge output stays low until the bus cycle engine reports that the transfer is done. The block then keeps the bus released for a fixed number of cycles before it accepts the next request. While a request is pending, while the transfer runs and while the bus is being released, the request line has no effect.

Clearing the enable stops sampling at once and drops a request that has not yet been granted. A transfer that has already started always runs to completion. If the request line is still low when acceptance reopens, the next transfer follows straight away, still separated by the release period.

Top module: `dreq_seq`

## Requirements
- R1: After reset, brk_req is 0, dack_n is 1 and the channel is disabled, so a low dreq_n causes no bus-break request until the enable is written.
- R2: A write with cfg_we=1 and cfg_en=1 stores the enable at the edge that ends the write cycle. A low dreq_n can be captured no earlier than the following edge.
- R3: When dreq_n is low at an edge while the block is idle and enabled, brk_req is 1 from the next cycle on. It stays 1 until the request is granted or dropped.
- R4: An edge with brk_gnt=1 while brk_req=1 clears the pending request and starts the transfer. In the next cycle brk_req is 0 and dack_n is 0.
- R5: dack_n stays 0 until the first edge at which xfer_done=1, and is 1 from the next cycle.
- R6: dreq_n is ignored from the capture edge until acceptance reopens. A low level that ends before then starts no further transfer.
- R7: After each transfer, brk_req stays 0 for at least REL_CYC+1 cycles (default REL_CYC=2). If dreq_n is held low, it stays 0 for exactly that long.
- R8: A write with cfg_we=1 and cfg_en=0 while a request is pending drops it. brk_req is 0 from the next cycle, no transfer follows, and later low levels are ignored.
- R9: Clearing the enable during a transfer does not shorten it. dack_n stays 0 until xfer_done, and no further request is captured.
- R10: brk_gnt has no effect unless a request is pending, and xfer_done has no effect unless a transfer is running.
- R11: A dreq_n held low continuously produces back-to-back transfers, each starting with a new bus-break request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the channel enable bit |
| cfg_en | input | 1 | Enable value carried by the write |
| dreq_n | input | 1 | Active-low level-sensitive DMA request |
| brk_gnt | input | 1 | Arbiter grants the requested bus break |
| xfer_done | input | 1 | Bus cycle engine reports the single transfer finished |
| brk_req | output | 1 | Request to the arbiter for a bus break (request pending) |
| dack_n | output | 1 | Active-low acknowledge, low for the transfer period |

## Verification
The hardest situations to reach from the ports are the ones where an enable write lands at the same edge as another event. Examples are a disable write arriving while a request waits for its grant, or while a transfer is in flight. A directed sequence sets these up by holding the grant back and issuing the write during the wait or the transfer. Random stimulus then makes writes, grants, completions and request levels coincide in many combinations. The back-to-back release spacing is measured by holding the request low across consecutive transfers and counting the cycles in which the bus-break request is low.

// File: rtl/dreq_seq.sv
module dreq_seq #(
  parameter int REL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_en,
  input  logic dreq_n,
  input  logic brk_gnt,
  input  logic xfer_done,
  output logic brk_req,
  output logic dack_n
);
  localparam int CW = (REL_CYC > 1) ? $clog2(REL_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_XFER, S_REL} st_t;

  st_t           st;
  logic          chan_en;
  logic [CW-1:0] rel_cnt;
  logic          stop;

  assign stop    = cfg_we && !cfg_en;
  assign brk_req = (st == S_PEND);
  assign dack_n  = (st != S_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      chan_en <= 1'b0;
      rel_cnt <= '0;
    end else begin
      if (cfg_we) chan_en <= cfg_en;
      case (st)
        S_IDLE: if (chan_en && !stop && !dreq_n) st <= S_PEND;
        S_PEND: begin
          if (stop)         st <= S_IDLE;
          else if (brk_gnt) st <= S_XFER;
        end
        S_XFER: if (xfer_done) begin
          st      <= S_REL;
          rel_cnt <= '0;
        end
        default: begin
          if (rel_cnt == CW'(REL_CYC - 1)) st <= S_IDLE;
          else rel_cnt <= rel_cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

module dreq_seq_chk #(
  parameter int REL_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic cfg_en,
  input logic dreq_n,
  input logic brk_gnt,
  input logic xfer_done,
  input logic brk_req,
  input logic dack_n,
  input logic chan_en
);
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)               gap <= 8'hFF;
    else if (!dack_n)         gap <= 8'd0;
    else if (gap != 8'hFF)    gap <= gap + 8'd1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !brk_req && dack_n);

  // R2
  no_capture_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !brk_req) |=> !brk_req);

  // R3
  capture_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> ($past(!dreq_n) && $past(chan_en)));

  // R4
  grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && brk_gnt && !(cfg_we && !cfg_en)) |=> (!dack_n && !brk_req));

  // R5
  hold_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dack_n && !xfer_done) |=> !dack_n);

  // R5
  end_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dack_n && xfer_done) |=> dack_n);

  // R7
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> (gap > 8'(REL_CYC)));

  // R8
  drop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && cfg_we && !cfg_en) |=> (!brk_req && dack_n));

  // R10
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_req && !dack_n));
endmodule

bind dreq_seq dreq_seq_chk #(.REL_CYC(REL_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
  .dreq_n(dreq_n), .brk_gnt(brk_gnt), .xfer_done(xfer_done),
  .brk_req(brk_req), .dack_n(dack_n), .chan_en(chan_en)
);

// File: tb/dreq_seq_tb.sv
module dreq_seq_tb_top;
  localparam int CLK_PER = 10;
  localparam int REL     = 2;

  logic clk = 1'b0;
  logic rst_n, cfg_we, cfg_en, dreq_n, brk_gnt, xfer_done;
  logic brk_req, dack_n;
  int   checks = 0, errors = 0;

  int m_st, m_cnt;
  bit m_en;

  always #(CLK_PER/2) clk = ~clk;

  dreq_seq #(.REL_CYC(REL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .dreq_n(dreq_n), .brk_gnt(brk_gnt), .xfer_done(xfer_done),
    .brk_req(brk_req), .dack_n(dack_n)
  );

  function automatic bit exp_brk(int s);
    return s == 1;
  endfunction

  function automatic bit exp_dack(int s);
    return s != 2;
  endfunction

  task automatic model_step(bit we, bit en, bit dq, bit g, bit d);
    bit stop = we && !en;
    case (m_st)
      0: if (m_en && !stop && !dq) m_st = 1;
      1: if (stop) m_st = 0; else if (g) m_st = 2;
      2: if (d) begin m_st = 3; m_cnt = 0; end
      default: if (m_cnt == REL - 1) m_st = 0; else m_cnt++;
    endcase
    if (we) m_en = en;
  endtask

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(bit we, bit en, bit dq, bit g, bit d);
    @(negedge clk);
    cfg_we = we; cfg_en = en; dreq_n = dq; brk_gnt = g; xfer_done = d;
    if (rst_n) model_step(we, en, dq, g, d);
    @(posedge clk);
    #(CLK_PER/4);
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 0; cfg_en = 0; dreq_n = 0; brk_gnt = 0; xfer_done = 0;
    m_st = 0; m_cnt = 0; m_en = 0;
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    chk("R1 brk_req after reset", brk_req, 1'b0);
    chk("R1 dack_n after reset", dack_n, 1'b1);
    repeat (3) drive(0, 0, 0, 0, 0);
    chk("R1 disabled ignores low request", brk_req, 1'b0);

    drive(1, 1, 0, 0, 0);
    chk("R2 no capture on enable edge", brk_req, 1'b0);
    drive(0, 0, 0, 0, 0);
    chk("R3 capture on next edge", brk_req, 1'b1);
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 1, 0, 0);
    chk("R3 pending held without grant", brk_req, 1'b1);
    chk("R3 no ack before grant", dack_n, 1'b1);
    drive(0, 0, 1, 1, 0);
    chk("R4 brk_req clears on grant", brk_req, 1'b0);
    chk("R4 dack_n low on grant", dack_n, 1'b0);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0);
    chk("R5 ack held until done", dack_n, 1'b0);
    chk("R6 request ignored during transfer", brk_req, 1'b0);
    drive(0, 0, 1, 0, 1);
    chk("R5 ack released after done", dack_n, 1'b1);
    repeat (4) drive(0, 0, 1, 0, 0);
    chk("R6 earlier low pulse not remembered", brk_req, 1'b0);

    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1);
    n = 0;
    if (!brk_req) n++;
    for (int i = 0; i < 10; i++) begin
      drive(0, 0, 0, 0, 0);
      if (brk_req) break;
      n++;
    end
    chk("R7 release gap length", n == REL + 1, 1'b1);
    chk("R11 back-to-back request raised", brk_req, 1'b1);

    drive(1, 0, 0, 0, 0);
    chk("R8 pending dropped", brk_req, 1'b0);
    chk("R8 no transfer after drop", dack_n, 1'b1);
    repeat (3) drive(0, 0, 0, 1, 0);
    chk("R8 disabled ignores request", brk_req, 1'b0);
    chk("R10 grant ignored when idle", dack_n, 1'b1);

    drive(1, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 1);
    chk("R10 done ignored while pending", brk_req, 1'b1);
    drive(0, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 0);
    chk("R9 transfer continues after disable", dack_n, 1'b0);
    drive(0, 0, 0, 0, 0);
    chk("R9 transfer still running", dack_n, 1'b0);
    drive(0, 0, 0, 0, 1);
    chk("R9 transfer ends on done", dack_n, 1'b1);
    repeat (5) drive(0, 0, 0, 0, 0);
    chk("R9 no capture after disable", brk_req, 1'b0);

    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 20) == 0;
      bit en = ($urandom % 5) != 0;
      bit dq = ($urandom % 3) == 0;
      bit g  = ($urandom % 2) == 0;
      bit d  = ($urandom % 3) == 0;
      drive(we, en, dq, g, d);
      chk("R3 random brk_req", brk_req, exp_brk(m_st));
      chk("R4 random dack_n", dack_n, exp_dack(m_st));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule